// File: doc/BRIEF.md
# Free-Running Microsecond Timer with Compare Channels

This peripheral keeps a 64-bit count that advances by one on every clock cycle in which the `tick_en` input is high. The surrounding logic pulses `tick_en` once per microsecond. Software reads the count as two 32-bit words. It can load four 32-bit compare values.

On a tick, the next value of the count is checked against every compare register. If the low 32 bits of that next value equal compare register n, pending bit n is set in the status word. The single `irq` output is high while any pending bit is set. Software acknowledges an event by writing a one to the matching status bit.

Access is through a plain 32-bit register port that uses a byte offset in a 32-byte window.
- A request is accepted in every cycle in which `req_valid` is high. There is no back-pressure.
- Read data returns exactly one cycle after a read request, marked by `rsp_valid`.
- Writes return nothing.

Offsets used by this block:

| Offset | Register |
|---|---|
| 0x00 | status |
| 0x04 | count bits 31:0 |
| 0x08 | count bits 63:32 |
| 0x0C + 4n | compare register n, for n = 0 to 3 |

Top module: `systmr`

## Requirements
- R1: After reset, the count, every compare register and every status bit are zero, and `irq` is low.
- R2: The count increases by one at each clock edge where `tick_en` is high and holds otherwise, wrapping modulo 2^64. A read of offset 0x04 returns count bits 31:0, and a read of offset 0x08 returns bits 63:32.
- R3: Writes to offsets 0x04 and 0x08 leave the count unchanged.
- R4: Compare register n is read and written at offset 0x0C + 4n, for n = 0 to 3, and a read returns the last value written.
- R5: On a clock edge where `tick_en` is high and the low 32 bits of the incremented count equal compare register n, status bit n becomes set at that same edge.
- R6: A write to offset 0x00 clears every status bit n whose write-data bit n is one and leaves the others. A status read returns bit n in position n, and bits 31:4 read as zero.
- R7: If a match and a clearing write hit the same status bit at the same edge, the bit ends set.
- R8: `irq` is high exactly when at least one status bit is set. It follows the status register with no further delay.
- R9: A read of any other offset returns zero. This includes 0x1C and offsets that are not a multiple of 4. A write to such an offset changes nothing.
- R10: `rsp_valid` is high in the cycle after a read request and only then. `rsp_rdata` holds the register value from before that request's clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-advance enable, one pulse per microsecond |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte offset within the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Level interrupt, OR of pending bits |

## Verification
The bench builds the block with its default parameters: a 32-bit data word, four compare channels and a 5-bit offset. At these values every compare channel and every mapped and unmapped offset can be reached. The low half of the count can be driven to any chosen match value in a few ticks. Carry into the high half and the 64-bit wrap cannot be reached in a run of practical length, so the high word is checked only at zero.

// File: rtl/systmr_pkg.sv
package systmr_pkg;
  localparam int unsigned OFS_STAT = 'h00;
  localparam int unsigned OFS_CLO  = 'h04;
  localparam int unsigned OFS_CHI  = 'h08;
  localparam int unsigned OFS_CMP0 = 'h0C;
  localparam int unsigned OFS_STEP = 4;
endpackage

// File: rtl/systmr_counter.sv
module systmr_counter #(
  parameter int unsigned CW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_nxt
);
  assign cnt_nxt = cnt_q + CW'(tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt_q == $past(cnt_q) + CW'(1));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
endmodule

// File: rtl/systmr_channel.sv
module systmr_channel #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_we,
  input  logic [DW-1:0] cmp_wd,
  input  logic          clr,
  input  logic          tick,
  input  logic [DW-1:0] cnt_lo_nxt,
  output logic [DW-1:0] cmp_q,
  output logic          pend_q,
  output logic          match
);
  assign match = tick && (cnt_lo_nxt == cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (cmp_we) cmp_q <= cmp_wd;
      pend_q <= match | (pend_q & ~clr);
    end
  end

  a_r7_match_wins: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> pend_q);
  a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !match) |=> !pend_q);
  a_r4_cmp_load: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we |=> cmp_q == $past(cmp_wd));
endmodule

// File: rtl/systmr.sv
module systmr
  import systmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_CMP  = 4,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq
);
  localparam int unsigned CNT_W = 2 * DATA_W;
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_CLO  = ADDR_W'(OFS_CLO);
  localparam logic [ADDR_W-1:0] A_CHI  = ADDR_W'(OFS_CHI);

  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic [N_CMP-1:0]  pend, hit, cmp_sel;
  logic [DATA_W-1:0] cmp_val [N_CMP];
  logic              rd_req, wr_req, stat_sel;
  logic [DATA_W-1:0] rd_mux;

  assign rd_req   = req_valid && !req_write;
  assign wr_req   = req_valid && req_write;
  assign stat_sel = (req_addr == A_STAT);

  systmr_counter #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_en),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt)
  );

  for (genvar n = 0; n < N_CMP; n++) begin : g_ch
    assign cmp_sel[n] = (req_addr == ADDR_W'(OFS_CMP0 + n * OFS_STEP));
    systmr_channel #(.DW(DATA_W)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .cmp_we(wr_req && cmp_sel[n]),
      .cmp_wd(req_wdata),
      .clr(wr_req && stat_sel && req_wdata[n]),
      .tick(tick_en),
      .cnt_lo_nxt(cnt_nxt[DATA_W-1:0]),
      .cmp_q(cmp_val[n]),
      .pend_q(pend[n]),
      .match(hit[n])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (stat_sel)            rd_mux = DATA_W'(pend);
    else if (req_addr == A_CLO) rd_mux = cnt_q[DATA_W-1:0];
    else if (req_addr == A_CHI) rd_mux = cnt_q[CNT_W-1:DATA_W];
    for (int n = 0; n < N_CMP; n++)
      if (cmp_sel[n]) rd_mux = cmp_val[n];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_rdata <= rd_mux;
    end
  end

  assign irq = |pend;

  a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rsp_valid);
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && stat_sel) |=> (rsp_rdata[DATA_W-1:N_CMP] == '0));
  a_r8_irq_after_match: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> irq);
endmodule

// File: tb/sim_systmr.sv
module sim_systmr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, irq;
  logic [31:0] rsp_rdata;

  int checks = 0, errors = 0;
  int cyc = 0;
  bit auto_tick = 1'b0;

  always #2 clk = ~clk;

  systmr u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
  );

  // behavioural reference model
  longint unsigned m_cnt;
  logic [31:0] m_cmp [4];
  logic [3:0]  m_st;
  bit          m_rv;
  logic [31:0] m_rd;
  string       m_tag;

  function automatic string tag_of(logic [4:0] a);
    if (a == 5'h00) return "R6";
    if (a == 5'h04 || a == 5'h08) return "R2";
    if (a >= 5'h0C && a <= 5'h18 && a[1:0] == 2'b00) return "R4";
    return "R9";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_st = '0; m_rv = 0; m_rd = '0; m_tag = "R10";
      foreach (m_cmp[i]) m_cmp[i] = '0;
    end else begin
      longint unsigned nxt;
      logic [3:0] st;
      m_rv = req_valid && !req_write;
      if (m_rv) begin
        m_tag = tag_of(req_addr);
        case (req_addr)
          5'h00: m_rd = {28'd0, m_st};
          5'h04: m_rd = m_cnt[31:0];
          5'h08: m_rd = m_cnt[63:32];
          5'h0C: m_rd = m_cmp[0];
          5'h10: m_rd = m_cmp[1];
          5'h14: m_rd = m_cmp[2];
          5'h18: m_rd = m_cmp[3];
          default: m_rd = '0;
        endcase
      end
      nxt = m_cnt + (tick_en ? 64'd1 : 64'd0);
      st = m_st;
      if (req_valid && req_write && req_addr == 5'h00) st = st & ~req_wdata[3:0];
      for (int n = 0; n < 4; n++)
        if (tick_en && nxt[31:0] == m_cmp[n]) st[n] = 1'b1;
      if (req_valid && req_write)
        for (int n = 0; n < 4; n++)
          if (req_addr == 5'(12 + 4 * n)) m_cmp[n] = req_wdata;
      m_st = st;
      m_cnt = nxt;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    check("R8", {31'd0, irq}, {31'd0, |m_st});
    check("R10", {31'd0, rsp_valid}, {31'd0, m_rv});
    if (m_rv) check(m_tag, rsp_rdata, m_rd);
  end

  task automatic drive(bit v, bit w, logic [4:0] a, logic [31:0] d, bit tk);
    @(negedge clk);
    cyc++;
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    tick_en = auto_tick ? (cyc % 3 == 0) : tk;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 5'h0, '0, 0);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    drive(1, 1, a, d, 0);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 5'h0, '0, 1);
  endtask

  // read with a literal expectation; data sampled one cycle later (R10)
  task automatic expect_read(logic [4:0] a, logic [31:0] exp, string req);
    drive(1, 0, a, '0, 0);
    drive(0, 0, 5'h0, '0, 0);
    check("R10", {31'd0, rsp_valid}, 32'd1);
    check(req, rsp_rdata, exp);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    idle(2);
    // R1 reset values
    expect_read(5'h00, 32'd0, "R1");
    expect_read(5'h04, 32'd0, "R1");
    expect_read(5'h08, 32'd0, "R1");
    for (int n = 0; n < 4; n++) expect_read(5'(12 + 4 * n), 32'd0, "R1");
    // R4 compare read/write
    for (int n = 0; n < 4; n++) wr(5'(12 + 4 * n), 32'hA5A5_0000 + n);
    for (int n = 0; n < 4; n++) expect_read(5'(12 + 4 * n), 32'hA5A5_0000 + n, "R4");
    // R2 counting
    ticks(5);
    expect_read(5'h04, 32'd5, "R2");
    expect_read(5'h08, 32'd0, "R2");
    // R3 counter writes ignored
    wr(5'h04, 32'hDEAD_BEEF);
    wr(5'h08, 32'd1);
    expect_read(5'h04, 32'd5, "R3");
    expect_read(5'h08, 32'd0, "R3");
    // R9 unmapped offsets
    expect_read(5'h1C, 32'd0, "R9");
    expect_read(5'h05, 32'd0, "R9");
    wr(5'h1C, 32'hFFFF_FFFF);
    wr(5'h0D, 32'h1234_5678);
    expect_read(5'h0C, 32'hA5A5_0000, "R9");
    expect_read(5'h00, 32'd0, "R9");
    // R5 match on channel 1 at count 8
    wr(5'h10, 32'd8);
    ticks(3);
    expect_read(5'h00, 32'd2, "R5");
    check("R8", {31'd0, irq}, 32'd1);
    // R6 write-one-to-clear, upper bits read zero
    wr(5'h00, 32'hFFFF_FFFD);
    expect_read(5'h00, 32'd2, "R6");
    wr(5'h00, 32'd2);
    idle(1);
    check("R8", {31'd0, irq}, 32'd0);
    expect_read(5'h00, 32'd0, "R6");
    // R7 match and clear collide on channel 2 (count 8 -> 9)
    wr(5'h14, 32'd9);
    drive(1, 1, 5'h00, 32'd4, 1);
    idle(1);
    check("R8", {31'd0, irq}, 32'd1);
    expect_read(5'h00, 32'd4, "R7");
    wr(5'h00, 32'hF);
    idle(1);
    check("R8", {31'd0, irq}, 32'd0);
    // free-running traffic checked against the model
    auto_tick = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      int unsigned r = $urandom % 8;
      if (r == 0)
        wr(5'(12 + 4 * ($urandom % 4)), m_cnt[31:0] + ($urandom % 12));
      else if (r == 1) wr(5'h00, $urandom);
      else if (r < 5)  drive(1, 0, 5'($urandom % 32), '0, 0);
      else             drive(0, 0, 5'h0, '0, 0);
    end
    auto_tick = 1'b0;
    idle(3);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule